// File: doc/BRIEF.md
# Keyboard Code Ring Buffer

This block sits between a keyboard receiver and a processor. The receiver presents each finished key code as a one-cycle valid strobe with a 32-bit code. The block stores the codes in a small circular queue. The processor drains that queue through a memory-mapped register window, using ordinary loads and stores.

Every piece of state has exactly one writer. The processor alone moves the read pointer (head). The keyboard side alone moves the write pointer (tail) and fills the storage slots. The queue is full when advancing tail would make it equal to head. One slot therefore always stays unused, and no shared occupancy count is needed. An empty queue is seen by software as head equal to tail.

Software consumes a code in two steps. It loads the slot that head points at, then stores head plus one back into the head register. A saturating counter records codes that were rejected because the queue was full.

Top module: `kbd_ring_top`

## Requirements
- R1: After reset, head (offset 0x00), tail (offset 0x04), the drop counter (offset 0x08) and every slot read as zero.
- R2: A valid code that arrives while the queue is not full is stored at the slot indexed by tail, and tail reads one higher from the next cycle on.
- R3: A valid code that arrives while tail equals head minus one (modulo DEPTH) is discarded: tail and every slot keep their values.
- R4: Each discarded code adds one to the drop counter. The counter stops at 255 and stays there.
- R5: With head held still, the queue accepts exactly DEPTH-1 codes (15 at the default DEPTH of 16) before it starts discarding.
- R6: A processor store to offset 0x00 sets head to the written value modulo DEPTH, and the new value reads back from the next cycle on.
- R7: Processor stores to offset 0x04, offset 0x08 and the slot window leave tail, the drop counter and the slots unchanged.
- R8: Tail wraps from DEPTH-1 to 0, and the next accepted code after the wrap lands in slot 0.
- R9: Slot i reads at byte offset 0x40 + 4*i. Any other offset, including unaligned ones and offsets past the window, reads as zero. Reads are combinational.
- R10: When a code arrives in the same cycle as a head store, the full decision uses the head value from before the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | One-cycle strobe: a new code is present |
| key_code | input | DATA_W | Code delivered by the keyboard receiver |
| cpu_addr | input | ADDR_W | Byte offset within the register window |
| cpu_we | input | 1 | Processor store strobe |
| cpu_wdata | input | DATA_W | Processor store data |
| cpu_rdata | output | DATA_W | Read data for cpu_addr, combinational |

## Verification
A wrong pointer shows at the ports in the very next cycle, because head and tail both read back directly.

A wrong full decision is different. It does not show when it happens. It shows later, as a drop counter that is off by one, or as a slot that was overwritten even though it should have been protected. The bench therefore re-reads the drop counter and the slot contents after each boundary event: one code short of full, exactly full, a wrap of tail, and a head store in the same cycle as an arrival. Because reads are combinational, every state error is visible within one clock of the edge that caused it.

// File: rtl/kbd_ring_pkg.sv
package kbd_ring_pkg;
    // Byte offsets of the register window
    localparam int unsigned OFF_HEAD  = 'h00;
    localparam int unsigned OFF_TAIL  = 'h04;
    localparam int unsigned OFF_DROP  = 'h08;
    localparam int unsigned OFF_SLOT  = 'h40;

    // Drop counter geometry
    localparam int unsigned DROP_W    = 8;
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    // Which source drives the read data
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_HEAD,
        SEL_TAIL,
        SEL_DROP,
        SEL_SLOT
    } rd_sel_e;
endpackage

// File: rtl/kbd_ring_head.sv
module kbd_ring_head
    import kbd_ring_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [PTR_W-1:0]  head_o
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
    } head_st_t;

    head_st_t st_d, st_q;
    logic     head_wr;

    // Only the pointer bits of the store data matter
    logic unused_wdata;
    assign unused_wdata = ^cpu_wdata[DATA_W-1:PTR_W];

    always_comb begin
        st_d    = st_q;
        head_wr = cpu_we && (cpu_addr == ADDR_W'(OFF_HEAD));
        if (head_wr) begin
            st_d.head = cpu_wdata[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o = st_q.head;

    // A head store takes effect on the next edge
    assert_head_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == ADDR_W'(OFF_HEAD)) |=> (head_o == $past(cpu_wdata[PTR_W-1:0])));

    // Without a head store, head holds
    assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == ADDR_W'(OFF_HEAD)) |=> $stable(head_o));
endmodule

// File: rtl/kbd_ring_fill.sv
module kbd_ring_fill
    import kbd_ring_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_code,
    input  logic [PTR_W-1:0]  head_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [PTR_W-1:0]  tail_o,
    output logic [DROP_W-1:0] drop_o,
    output logic [DATA_W-1:0] slot_rdata_o
);
    typedef struct packed {
        logic [PTR_W-1:0]              tail;
        logic [DROP_W-1:0]             drop;
        logic [DEPTH-1:0][DATA_W-1:0]  slot;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic     full;
    logic     take;
    logic     reject;

    always_comb begin
        st_d   = st_q;
        full   = (PTR_W'(st_q.tail + 1'b1) == head_i);
        take   = key_valid && !full;
        reject = key_valid && full;
        if (take) begin
            st_d.slot[st_q.tail] = key_code;
            st_d.tail            = PTR_W'(st_q.tail + 1'b1);
        end
        if (reject && (st_q.drop != DROP_MAX)) begin
            st_d.drop = st_q.drop + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail_o       = st_q.tail;
    assign drop_o       = st_q.drop;
    assign slot_rdata_o = st_q.slot[rd_idx_i];

    // An arrival with room advances tail by exactly one, wrapping
    assert_tail_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && PTR_W'(tail_o + 1'b1) != head_i) |=> (PTR_W'(tail_o - $past(tail_o)) == PTR_W'(1)));

    // An arrival while full leaves tail alone
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && PTR_W'(tail_o + 1'b1) == head_i) |=> $stable(tail_o));

    // Tail only moves on an arrival
    assert_tail_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> $stable(tail_o));

    // Counter never leaves its ceiling
    assert_drop_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_o == DROP_MAX) |=> (drop_o == DROP_MAX));

    // Counter only moves when a code is rejected
    assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_valid && PTR_W'(tail_o + 1'b1) == head_i) |=> $stable(drop_o));
endmodule

// File: rtl/kbd_ring_rdport.sv
module kbd_ring_rdport
    import kbd_ring_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned SPAN  = DEPTH * 4
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [PTR_W-1:0]  head_i,
    input  logic [PTR_W-1:0]  tail_i,
    input  logic [DROP_W-1:0] drop_i,
    input  logic [DATA_W-1:0] slot_rdata_i,
    output logic [PTR_W-1:0]  rd_idx_o,
    output logic [DATA_W-1:0] cpu_rdata
);
    rd_sel_e           sel;
    logic [ADDR_W-1:0] off;

    always_comb begin
        off      = cpu_addr - ADDR_W'(OFF_SLOT);
        rd_idx_o = off[PTR_W+1:2];
        sel      = SEL_NONE;
        if (cpu_addr == ADDR_W'(OFF_HEAD)) begin
            sel = SEL_HEAD;
        end else if (cpu_addr == ADDR_W'(OFF_TAIL)) begin
            sel = SEL_TAIL;
        end else if (cpu_addr == ADDR_W'(OFF_DROP)) begin
            sel = SEL_DROP;
        end else if ((cpu_addr >= ADDR_W'(OFF_SLOT)) &&
                     (int'(cpu_addr) < int'(OFF_SLOT + SPAN)) &&
                     (cpu_addr[1:0] == 2'b00)) begin
            sel = SEL_SLOT;
        end
    end

    always_comb begin
        case (sel)
            SEL_HEAD: cpu_rdata = DATA_W'(head_i);
            SEL_TAIL: cpu_rdata = DATA_W'(tail_i);
            SEL_DROP: cpu_rdata = DATA_W'(drop_i);
            SEL_SLOT: cpu_rdata = slot_rdata_i;
            default:  cpu_rdata = '0;
        endcase
    end

    logic unused_off;
    assign unused_off = ^{off[ADDR_W-1:PTR_W+2], off[1:0]};

    // Unmapped offsets read as zero
    always_comb begin
        if (sel == SEL_NONE) begin
            assert_unmapped_zero_R9: assert (cpu_rdata == '0);
        end
    end
endmodule

// File: rtl/kbd_ring_top.sv
module kbd_ring_top
    import kbd_ring_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_code,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0]  head_w;
    logic [PTR_W-1:0]  tail_w;
    logic [PTR_W-1:0]  rd_idx_w;
    logic [DROP_W-1:0] drop_w;
    logic [DATA_W-1:0] slot_rdata_w;

    kbd_ring_head #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_head (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .head_o    (head_w)
    );

    kbd_ring_fill #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_valid    (key_valid),
        .key_code     (key_code),
        .head_i       (head_w),
        .rd_idx_i     (rd_idx_w),
        .tail_o       (tail_w),
        .drop_o       (drop_w),
        .slot_rdata_o (slot_rdata_w)
    );

    kbd_ring_rdport #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .cpu_addr     (cpu_addr),
        .head_i       (head_w),
        .tail_i       (tail_w),
        .drop_i       (drop_w),
        .slot_rdata_i (slot_rdata_w),
        .rd_idx_o     (rd_idx_w),
        .cpu_rdata    (cpu_rdata)
    );
endmodule

// File: tb/test_kbd_ring_top.sv
module test_kbd_ring_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              key_valid = 1'b0;
    logic [DATA_W-1:0] key_code = '0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_we = 1'b0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_ring_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_kbd_ring_top (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    task automatic expect_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string req);
        cpu_addr = a;
        #1;
        n_chk++;
        if (cpu_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, cpu_rdata, exp);
        end
    endtask

    task automatic push(input logic [DATA_W-1:0] c);
        @(negedge clk);
        key_valid = 1'b1; key_code = c;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic t_reset();
        expect_rd(8'h00, 0, "R1 head");
        expect_rd(8'h04, 0, "R1 tail");
        expect_rd(8'h08, 0, "R1 drop");
        expect_rd(8'h40, 0, "R1 slot0");
        expect_rd(8'h7C, 0, "R1 slot15");
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH-1; i++) begin
            push(32'h100 + i);
            expect_rd(8'h04, i+1, "R2 tail step");
        end
        expect_rd(8'h40, 32'h100, "R9 slot0");
        expect_rd(8'h40 + 4*14, 32'h10E, "R9 slot14");
        push(32'hDEAD_BEEF);
        expect_rd(8'h04, 15, "R5 capacity tail");
        expect_rd(8'h7C, 0, "R3 slot15 untouched");
        expect_rd(8'h08, 1, "R4 drop one");
    endtask

    task automatic t_consume_wrap();
        expect_rd(8'h40, 32'h100, "R9 read at head");
        store(8'h00, 32'hFFFF_FFF1);
        expect_rd(8'h00, 1, "R6 head modulo");
        push(32'hA5A5_0015);
        expect_rd(8'h7C, 32'hA5A5_0015, "R8 slot15");
        expect_rd(8'h04, 0, "R8 tail wrap");
        push(32'hBAD0_0000);
        expect_rd(8'h08, 2, "R3 full after wrap");
        expect_rd(8'h40, 32'h100, "R3 slot0 kept");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 8'h00; cpu_wdata = 32'd2;
        key_valid = 1'b1; key_code = 32'hBAD0_0001;
        @(negedge clk);
        cpu_we = 1'b0; key_valid = 1'b0;
        expect_rd(8'h08, 3, "R10 drop uses old head");
        expect_rd(8'h04, 0, "R10 tail held");
        expect_rd(8'h00, 2, "R10 head stored");
        expect_rd(8'h40, 32'h100, "R10 slot0 kept");
        push(32'hC0DE_0000);
        expect_rd(8'h40, 32'hC0DE_0000, "R8 slot0 after wrap");
        expect_rd(8'h04, 1, "R2 tail after wrap");
    endtask

    task automatic t_ignored();
        store(8'h04, 32'd5);
        expect_rd(8'h04, 1, "R7 tail store ignored");
        store(8'h08, 32'd9);
        expect_rd(8'h08, 3, "R7 drop store ignored");
        store(8'h40, 32'h1234_5678);
        expect_rd(8'h40, 32'hC0DE_0000, "R7 slot store ignored");
        expect_rd(8'h00, 2, "R7 head untouched");
    endtask

    task automatic t_unmapped();
        expect_rd(8'h0C, 0, "R9 gap");
        expect_rd(8'h41, 0, "R9 unaligned");
        expect_rd(8'h80, 0, "R9 past window");
        expect_rd(8'hFC, 0, "R9 top");
    endtask

    task automatic t_saturate();
        @(negedge clk);
        key_valid = 1'b1; key_code = 32'hFEED_0000;
        for (int i = 0; i < 300; i++) @(negedge clk);
        key_valid = 1'b0;
        expect_rd(8'h08, 255, "R4 saturate");
        expect_rd(8'h04, 1, "R3 tail held while full");
        expect_rd(8'h44, 32'h101, "R3 slot1 kept");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_consume_wrap();
        t_same_cycle();
        t_ignored();
        t_unmapped();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule